// File: doc/BRIEF.md
# Multi-Depth Pixel Serialiser with Colour Palette

This block turns a stream of 32-bit frame-buffer words into one colour value per pixel clock. Words come from a first-word-fall-through FIFO. Each word is cut into pixels at a depth chosen by a host-written depth register: 1, 2, 4, 8, 16 or 32 bits per pixel. Pixels of 8 bits or fewer index a 256-entry colour table that the host fills. Each table entry is 28 bits wide: an 8-bit red, green and blue triple plus a 4-bit side field. The result drives three 8-bit converter inputs and a 4-bit side output.

At 16 bits per pixel the table is bypassed. Each pixel is read as three 5-bit fields, and each field is widened to 8 bits. At 32 bits per pixel the low 24 bits are passed through directly. A blanking input pauses the stream and forces the colour output to black. A pixel whose word is popped from the FIFO reaches the output two clocks later, and the next pixels follow one per clock. The design is meant for pixel rates up to 110 MHz, so each stage holds at most one table read or one shift.

Top module: `pixel_serialiser`

## Requirements
- R1: After reset, pix_valid, fifo_pop and all colour outputs are 0, and the depth register selects 8 bits per pixel (code 3).
- R2: A host write with host_addr=2 loads host_wdata[2:0] as the depth code: 0=1, 1=2, 2=4, 3=8, 4=16, 5=32 bits per pixel. Codes 6 and 7 are ignored, and the previous depth stays in force.
- R3: Pixels are taken from a word starting at the least significant bits. A word gives 32/bpp pixels, and fifo_pop is asserted only for the first pixel of each word.
- R4: At 1, 2, 4 and 8 bpp, the pixel value is zero-extended to an 8-bit palette index. The output is the entry's fields: side field from bits 27:24, red from 23:16, green from 15:8, blue from 7:0.
- R5: A host write with host_addr=0 sets the palette index to host_wdata[7:0]. A write with host_addr=1 stores host_wdata[27:0] at the index and then adds one to the index, so index 255 wraps to 0.
- R6: At 16 bpp, red comes from pixel bits 14:10, green from 9:5 and blue from 4:0. Each 5-bit field f becomes {f, f[4:2]}, bit 15 is ignored and the side field is 0.
- R7: At 32 bpp, red is bits 23:16, green is 15:8 and blue is 7:0. Bits 31:24 are ignored and the side field is 0.
- R8: While blank is 1, no word is popped and the position within the current word holds. Two clocks later pix_valid is 0 and all colour outputs are 0.
- R9: When a word is popped in cycle n, its first pixel is on the outputs with pix_valid=1 after the second rising edge that follows, and its remaining pixels come out on consecutive clocks.
- R10: At a word boundary with fifo_empty=1, nothing is popped, no pixel is produced, and the stream continues with the first pixel of the next word once it arrives.
- R11: Any write to the depth register (host_addr=2) restarts unpacking at the first pixel of the next word, which discards the rest of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 palette index, 1 palette data, 2 depth code |
| host_wdata | input | 28 | Host write data |
| fifo_word | input | 32 | Head word of the frame FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this edge |
| blank | input | 1 | Pause the stream and force black |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| pix_ext | output | 4 | Palette side field |
| pix_valid | output | 1 | A pixel is on the outputs this clock |

## Verification
Every depth is fed words whose pixels all differ: nibble ramps, alternating bits and walking patterns. A wrong shift amount, a reversed pixel order or a wrong field mask therefore gives a visible error. The 16 and 32 bpp words set the ignored top bits and use field values whose widened low bits differ from zero, so a missing replication or a leak from the top bits shows up. Blanking in mid-word, FIFO starvation and a depth write in mid-word each test a different way the stream can stop. Palette writes at index 255 and at a preset index separate the wrap and load behaviour from a plain sequential fill.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int WORD_W  = 32;
  localparam int COLOR_W = 8;
  localparam int EXT_W   = 4;
  localparam int ENTRY_W = 3 * COLOR_W + EXT_W;
  localparam int RAW_W   = 3 * COLOR_W;
  localparam int PAL_N   = 256;
  localparam int CODE_W  = 3;

  localparam logic [CODE_W-1:0] CODE_8BPP  = 3'd3;
  localparam logic [CODE_W-1:0] CODE_16BPP = 3'd4;
  localparam logic [CODE_W-1:0] CODE_32BPP = 3'd5;
  localparam logic [CODE_W-1:0] CODE_MAX   = 3'd5;

  localparam logic [1:0] HA_INDEX = 2'd0;
  localparam logic [1:0] HA_DATA  = 2'd1;
  localparam logic [1:0] HA_MODE  = 2'd2;

  // widen a 5-bit colour field to 8 bits by repeating its top bits
  function automatic logic [7:0] widen5(input logic [4:0] f);
    return {f, f[4:2]};
  endfunction
endpackage

// File: rtl/pxs_slot_ctrl.sv
module pxs_slot_ctrl
  import pxs_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int RW = RAW_W,
  parameter int SW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [CODE_W-1:0] mode_wdata,
  input  logic              blank,
  input  logic              fifo_empty,
  input  logic [WW-1:0]     fifo_word,
  output logic              fifo_pop,
  output logic              s1_valid,
  output logic [CODE_W-1:0] s1_code,
  output logic [RW-1:0]     s1_raw
);
  logic [CODE_W-1:0] depth_q, depth_d;
  logic [SW-1:0]     slot_q, slot_d;
  logic [WW-1:0]     word_q, cur_word;
  logic [SW:0]       npix;
  logic [SW-1:0]     shamt;
  logic              active, last, depth_en;
  logic [RW-1:0]     raw_d;

  always_comb begin
    npix     = (SW+1)'(WW) >> depth_q;
    last     = (slot_q == SW'(npix - 1'b1));
    fifo_pop = rst_n && !blank && (slot_q == '0) && !fifo_empty;
    active   = rst_n && !blank && ((slot_q != '0) || !fifo_empty);
    cur_word = (slot_q == '0) ? fifo_word : word_q;
    shamt    = slot_q << depth_q;
    raw_d    = RW'(cur_word >> shamt);
    depth_en = mode_we && (mode_wdata <= CODE_MAX);
    depth_d  = mode_wdata;
    slot_d   = slot_q;
    if (mode_we)     slot_d = '0;
    else if (active) slot_d = last ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q  <= CODE_8BPP;
      slot_q   <= '0;
      word_q   <= '0;
      s1_valid <= 1'b0;
      s1_code  <= CODE_8BPP;
      s1_raw   <= '0;
    end else begin
      if (depth_en) depth_q <= depth_d;
      slot_q   <= slot_d;
      if (fifo_pop) word_q <= fifo_word;
      s1_valid <= active;
      if (active) begin
        s1_code <= depth_q;
        s1_raw  <= raw_d;
      end
    end
  end

  // R8
  no_pop_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !fifo_pop);

  // R10
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == '0 && fifo_empty && !mode_we) |=> (slot_q == '0 && !s1_valid));

  // R2
  mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata > CODE_MAX) |=> $stable(depth_q));
endmodule

// File: rtl/pxs_palette.sv
module pxs_palette
  import pxs_pkg::*;
#(
  parameter int N  = PAL_N,
  parameter int EW = ENTRY_W,
  parameter int IW = $clog2(PAL_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [EW-1:0] host_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [EW-1:0] rd_entry
);
  logic [EW-1:0] mem [N];
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_wr, data_wr;

  always_comb begin
    idx_wr  = host_we && (host_addr == HA_INDEX);
    data_wr = host_we && (host_addr == HA_DATA);
    idx_d   = idx_q;
    if (idx_wr)       idx_d = host_wdata[IW-1:0];
    else if (data_wr) idx_d = idx_q + 1'b1;
    rd_entry = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[idx_q] <= host_wdata;
  end

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == HA_DATA) |=> idx_q == $past(idx_q) + IW'(1));
endmodule

// File: rtl/pxs_colour_out.sv
module pxs_colour_out
  import pxs_pkg::*;
#(
  parameter int RW = RAW_W,
  parameter int EW = ENTRY_W,
  parameter int IW = $clog2(PAL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [CODE_W-1:0] s1_code,
  input  logic [RW-1:0]     s1_raw,
  output logic [IW-1:0]     pal_idx,
  input  logic [EW-1:0]     pal_entry,
  output logic [EW-1:0]     out_entry,
  output logic              out_valid
);
  logic [IW-1:0] idx_mask;
  logic [EW-1:0] entry_d;

  always_comb begin
    idx_mask = {IW{1'b1}} >> (4'd8 - (4'd1 << s1_code));
    pal_idx  = s1_raw[IW-1:0] & idx_mask;
    case (s1_code)
      CODE_16BPP: entry_d = {4'h0, widen5(s1_raw[14:10]), widen5(s1_raw[9:5]),
                             widen5(s1_raw[4:0])};
      CODE_32BPP: entry_d = {4'h0, s1_raw[23:0]};
      default:    entry_d = pal_entry;
    endcase
    if (!s1_valid) entry_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_entry <= '0;
      out_valid <= 1'b0;
    end else begin
      out_entry <= entry_d;
      out_valid <= s1_valid;
    end
  end
endmodule

// File: rtl/pixel_serialiser.sv
module pixel_serialiser
  import pxs_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int CW = COLOR_W,
  parameter int XW = EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [3*CW+XW-1:0] host_wdata,
  input  logic [WW-1:0]     fifo_word,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              blank,
  output logic [CW-1:0]     pix_r,
  output logic [CW-1:0]     pix_g,
  output logic [CW-1:0]     pix_b,
  output logic [XW-1:0]     pix_ext,
  output logic              pix_valid
);
  localparam int EW = 3 * CW + XW;
  localparam int RW = 3 * CW;
  localparam int IW = $clog2(PAL_N);

  logic [1:0]        rs_q;
  logic              rst_int, mode_we;
  logic              s1_valid;
  logic [CODE_W-1:0] s1_code;
  logic [RW-1:0]     s1_raw;
  logic [IW-1:0]     pal_idx;
  logic [EW-1:0]     pal_entry, out_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  always_comb begin
    rst_int = rs_q[1];
    mode_we = host_we && (host_addr == HA_MODE);
    pix_ext = out_entry[EW-1 -: XW];
    pix_r   = out_entry[3*CW-1 -: CW];
    pix_g   = out_entry[2*CW-1 -: CW];
    pix_b   = out_entry[CW-1:0];
  end

  pxs_slot_ctrl #(.WW(WW), .RW(RW)) slot_i (
    .clk(clk), .rst_n(rst_int), .mode_we(mode_we),
    .mode_wdata(host_wdata[CODE_W-1:0]), .blank(blank),
    .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
    .s1_valid(s1_valid), .s1_code(s1_code), .s1_raw(s1_raw)
  );

  pxs_palette #(.EW(EW), .IW(IW)) pal_i (
    .clk(clk), .rst_n(rst_int), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .rd_idx(pal_idx), .rd_entry(pal_entry)
  );

  pxs_colour_out #(.RW(RW), .EW(EW), .IW(IW)) col_i (
    .clk(clk), .rst_n(rst_int), .s1_valid(s1_valid), .s1_code(s1_code),
    .s1_raw(s1_raw), .pal_idx(pal_idx), .pal_entry(pal_entry),
    .out_entry(out_entry), .out_valid(pix_valid)
  );

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !pix_valid |-> (out_entry == '0));

  // R9
  pop_latency_chk: assert property (@(posedge clk) disable iff (!rst_int)
    $past(fifo_pop, 2) |-> pix_valid);
endmodule

// File: tb/pixel_serialiser_tb_top.sv
`timescale 1ns/1ps
module pixel_serialiser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [27:0] host_wdata = '0;
  logic [31:0] fifo_word = '0;
  logic        fifo_empty = 1'b1;
  logic        blank = 1'b0;
  logic        fifo_pop, pix_valid;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic [3:0]  pix_ext;

  int total = 0;
  int bad = 0;
  int pop_cnt = 0;
  bit started = 1'b0;
  logic [31:0] fq[$];
  logic [27:0] exp_q[$];
  logic [27:0] pal_m [256];
  logic [2:0]  cur_code = 3'd3;

  pixel_serialiser dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .fifo_word(fifo_word), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .blank(blank), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .pix_ext(pix_ext), .pix_valid(pix_valid)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_word  = (fq.size() == 0) ? 32'h0 : fq[0];
  endtask

  // FIFO model: the pop seen at the edge takes effect just after it
  always @(posedge clk) begin
    if (fifo_pop) begin
      pop_cnt++;
      #1;
      void'(fq.pop_front());
      refresh();
    end
  end

  function automatic logic [7:0] wid(input logic [4:0] f);
    return {f, f[4:2]};
  endfunction

  function automatic logic [27:0] exp_pix(input logic [31:0] w, input logic [2:0] code,
                                          input int k);
    int bpp;
    logic [31:0] v;
    bpp = 1 << code;
    v = w >> (k * bpp);
    if (code <= 3)      return pal_m[v[7:0] & ((9'd1 << bpp) - 9'd1)];
    else if (code == 4) return {4'h0, wid(v[14:10]), wid(v[9:5]), wid(v[4:0])};
    else                return {4'h0, v[23:0]};
  endfunction

  function automatic logic [27:0] pe(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b[3:0], b, b ^ 8'hA5, ~b};
  endfunction

  task automatic send_word(input logic [31:0] w);
    fq.push_back(w);
    refresh();
    for (int k = 0; k < (32 >> cur_code); k++) exp_q.push_back(exp_pix(w, cur_code, k));
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [27:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || fq.size() != 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 stream drained", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (started) begin
      if (pix_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected pixel", {pix_ext, pix_r, pix_g, pix_b}, 0);
        end else begin
          logic [27:0] e;
          e = exp_q.pop_front();
          check({pix_ext, pix_r, pix_g, pix_b} == e, "R4/R6/R7 pixel value",
                {pix_ext, pix_r, pix_g, pix_b}, e);
        end
      end else begin
        check({pix_ext, pix_r, pix_g, pix_b} == 0, "R8 idle output black",
              {pix_ext, pix_r, pix_g, pix_b}, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    refresh();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(pix_valid == 0, "R1 valid low", pix_valid, 0);
    check({pix_ext, pix_r, pix_g, pix_b} == 0, "R1 outputs zero",
          {pix_ext, pix_r, pix_g, pix_b}, 0);
    check(fifo_pop == 0, "R1 no pop", fifo_pop, 0);
    started = 1'b1;

    // R5 sequential fill from index 0
    host_wr(2'd0, 28'd0);
    for (int i = 0; i < 256; i++) begin
      host_wr(2'd1, pe(i));
      pal_m[i] = pe(i);
    end

    // R1 default depth is 8 bpp, R4 indexing
    @(negedge clk);
    send_word(32'hFF00A55A);
    send_word(32'h807F0301);
    wait_drain();

    // R9 latency from pop to output
    @(negedge clk);
    blank = 1'b1;
    send_word(32'h12345678);
    @(negedge clk);
    blank = 1'b0;
    #1 check(fifo_pop == 1, "R9 pop on release", fifo_pop, 1);
    @(negedge clk);
    check(pix_valid == 0, "R9 not yet after one edge", pix_valid, 0);
    @(negedge clk);
    check(pix_valid == 1, "R9 valid after two edges", pix_valid, 1);
    wait_drain();

    // R11 depth write discards rest of word
    @(negedge clk);
    blank = 1'b1;
    fq.push_back(32'hDDCCBBAA);
    refresh();
    exp_q.push_back(pal_m[8'hAA]);
    exp_q.push_back(pal_m[8'hBB]);
    @(negedge clk);
    blank = 1'b0;
    @(negedge clk);
    @(negedge clk);
    blank = 1'b1;
    host_wr(2'd2, 28'd3);
    check(fq.size() == 0, "R11 word consumed", fq.size(), 0);
    @(negedge clk);
    blank = 1'b0;
    send_word(32'h44332211);
    wait_drain();

    // R2 every legal depth with several patterns, R3 pop count per word
    for (int c = 0; c <= 5; c++) begin
      host_wr(2'd2, 28'(c));
      cur_code = 3'(c);
      pop_cnt = 0;
      send_word(32'h76543210);
      send_word(32'hAAAA5555);
      send_word(32'h8000F001);
      send_word(32'hFEDCBA98);
      wait_drain();
      check(pop_cnt == 4, "R3 one pop per word", pop_cnt, 4);
    end

    // R7 top bits ignored at 32 bpp, R2 illegal codes keep 32 bpp
    host_wr(2'd2, 28'd6);
    host_wr(2'd2, 28'd7);
    send_word(32'hFF123456);
    send_word(32'h00ABCDEF);
    wait_drain();

    // R6 bit 15 ignored at 16 bpp
    host_wr(2'd2, 28'd4);
    cur_code = 3'd4;
    send_word(32'h7FFF8421);
    send_word(32'h0C63F39C);
    wait_drain();

    // R5 preset index and wrap
    host_wr(2'd0, 28'd200);
    host_wr(2'd1, 28'hABCDEF1); pal_m[200] = 28'hABCDEF1;
    host_wr(2'd1, 28'h1234567); pal_m[201] = 28'h1234567;
    host_wr(2'd0, 28'd255);
    host_wr(2'd1, 28'h0F0F0F0); pal_m[255] = 28'h0F0F0F0;
    host_wr(2'd1, 28'h5A5A5A5); pal_m[0]   = 28'h5A5A5A5;
    host_wr(2'd2, 28'd3);
    cur_code = 3'd3;
    send_word(32'h00FFC9C8);
    wait_drain();

    // R8 blank mid-word at 4 bpp
    host_wr(2'd2, 28'd2);
    cur_code = 3'd2;
    send_word(32'h13579BDF);
    send_word(32'h2468ACE0);
    repeat (3) @(negedge clk);
    blank = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1 check(fifo_pop == 0, "R8 no pop while blank", fifo_pop, 0);
      check(fq.size() == 1, "R8 FIFO untouched", fq.size(), 1);
      if (i >= 2) check(pix_valid == 0, "R8 output blanked", pix_valid, 0);
      @(negedge clk);
    end
    blank = 1'b0;
    wait_drain();

    // R10 starvation at word boundary at 2 bpp
    host_wr(2'd2, 28'd1);
    cur_code = 3'd1;
    send_word(32'hE4E4E4E4);
    wait_drain();
    for (int i = 0; i < 4; i++) begin
      check(fifo_pop == 0, "R10 no pop when empty", fifo_pop, 0);
      check(pix_valid == 0, "R10 no pixel when empty", pix_valid, 0);
      @(negedge clk);
    end
    send_word(32'h1B1B1B1B);
    wait_drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule